// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block drives a two-wire bus as its only master. It produces the clock and data waveforms one bit at a time from the system clock. Each bit is built from quarter-bit time units, and one unit lasts a parameterised number of system clocks. Both lines are open-drain. The engine owns one pull-low enable per line and reads both lines back through two-flop synchronisers. Whenever it lets the clock line go, it polls that line at a one-microsecond step until it reads high. This lets a slave hold the clock low to pause a transfer, and a bounded poll count turns a clock that never comes back into an error.

A host issues one command at a time while the engine is idle: start, stop, byte write, byte read with acknowledge, byte read with not-acknowledge, or a full register write. Every command ends with a one-cycle done pulse and a status code. The start and stop sequences first park the clock low, so they work from whatever levels the lines happen to hold.

Top module: `i2c_bit_master`

## Requirements
- R1: In every bit slot the engine pulls SCL low for exactly two time units (2*UNIT_CLKS system clocks). SDA is set one unit after SCL goes low. After SCL is seen high, the engine keeps it released for two more units.
- R2: Command code 0 (start) ends with SCL released and SDA pulled low. The only SDA edge it makes while SCL is high is one falling edge. It works when SDA was left low or high before.
- R3: Command code 1 (stop) ends with both lines released. The only SDA edge it makes while SCL is high is one rising edge.
- R4: Command code 2 (write) puts wdata_i on SDA most significant bit first, one bit per SCL rising edge. SDA never changes while SCL is high.
- R5: On the ninth clock of a write, SDA is released and sampled. A low level gives status 0 (ok) and a high level gives status 1 (no acknowledge).
- R6: Command codes 3 and 4 read eight bits, sampled while SCL is high and assembled MSB first into rdata_o. Code 3 pulls SDA low on the ninth clock and returns status 0.
- R7: Code 4 releases SDA on the ninth clock and samples it. If SDA reads low, the status is 2 (read not-acknowledge). If it reads high, the status is 0.
- R8: Command code 5 (register write) runs 29 bit slots in this order: start, dev_addr_i, reg_addr_i, wdata_i, stop. It finishes the whole sequence even when bytes are not acknowledged, and returns status 1 if any byte was not acknowledged, otherwise status 0.
- R9: A slave may hold SCL low after the engine releases it. If the hold ends within STRETCH_POLLS polls of CLK_MHZ clocks each, the command completes normally with the correct data.
- R10: If SCL stays low for the whole poll window, the command aborts with status 3. Both lines are then released, and done comes no sooner than STRETCH_POLLS*CLK_MHZ clocks after the release. The next command runs normally.
- R11: ready_o is high only when the engine is idle. Each accepted command yields exactly one single-cycle done_o pulse. Codes 6 and 7 are ignored. After reset the engine is idle with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken while ready_o is high |
| cmd_i | input | 3 | Command code (0 start, 1 stop, 2 write, 3 read+ack, 4 read+nack, 5 register write) |
| wdata_i | input | 8 | Byte for a write, or the data byte of a register write |
| dev_addr_i | input | 8 | Device address byte of a register write |
| reg_addr_i | input | 8 | Register address byte of a register write |
| ready_o | output | 1 | Engine idle and able to take a command |
| done_o | output | 1 | One-cycle pulse at the end of each command |
| status_o | output | 2 | Result of the last command (0 ok, 1 no ack, 2 read nack error, 3 stretch timeout) |
| rdata_o | output | 8 | Byte from the last read command |
| scl_i | input | 1 | SCL line level as seen on the bus |
| sda_i | input | 1 | SDA line level as seen on the bus |
| scl_drive_o | output | 1 | Pull SCL low when high |
| sda_drive_o | output | 1 | Pull SDA low when high |

## Verification
A corrupted bit counter or segment index shows up on the bus within one command. The bench would see the wrong number of SCL rising edges, a misplaced start or stop edge, or a wrong byte decoded from the captured SDA levels. A stuck sampling path gives a wrong rdata_o or status at the very next done pulse. A broken stretch poll either hangs the command or ends it early, and the bench sees this in the done timing measured against the poll window. The SCL low-time measurement in every slot exposes a unit timer that counts wrong within the first bit.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  typedef enum logic [2:0] {
    CMD_START = 3'd0, CMD_STOP = 3'd1, CMD_WRITE = 3'd2,
    CMD_READ_ACK = 3'd3, CMD_READ_NACK = 3'd4, CMD_REG_WRITE = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    ST_OK = 2'd0, ST_NOACK = 2'd1, ST_RDNACK = 2'd2, ST_TIMEOUT = 2'd3
  } status_e;

  typedef enum logic [1:0] {K_START, K_STOP, K_WR, K_RD} kind_e;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_DATA, S_REL, S_HIGH1, S_HIGH2} state_e;
endpackage

// File: rtl/i2c_bm_sync.sv
module i2c_bm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] r_q;

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r_q <= '1;
    else         r_q <= {r_q[STAGES-2:0], d_i};
  end

  assign q_o = r_q[STAGES-1];
endmodule

// File: rtl/i2c_bm_delay.sv
module i2c_bm_delay #(
  parameter int CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(CYCLES - 1);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = act_q && (cnt_q == '0);

  assert_delay_ends_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);
endmodule

// File: rtl/i2c_bm_stretch.sv
module i2c_bm_stretch #(
  parameter int STEP_CLKS = 4,
  parameter int POLLS     = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic scl_i,
  output logic ok_o,
  output logic timeout_o
);
  localparam int SW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam int PW = (POLLS > 1) ? $clog2(POLLS) : 1;

  logic [SW-1:0] step_q;
  logic [PW-1:0] poll_q;
  logic          act_q, tick, last;

  assign tick      = act_q && (step_q == '0);
  assign last      = (poll_q == PW'(POLLS - 1));
  assign ok_o      = tick && scl_i;
  assign timeout_o = tick && !scl_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      poll_q <= '0;
      act_q  <= 1'b0;
    end else if (start_i) begin
      step_q <= SW'(STEP_CLKS - 1);
      poll_q <= '0;
      act_q  <= 1'b1;
    end else if (tick) begin
      if (scl_i || last) act_q <= 1'b0;
      else begin
        poll_q <= poll_q + 1'b1;
        step_q <= SW'(STEP_CLKS - 1);
      end
    end else if (act_q) begin
      step_q <= step_q - 1'b1;
    end
  end

  assert_poll_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (poll_q <= PW'(POLLS - 1)));
  assert_single_outcome_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o || timeout_o) |=> !act_q);
endmodule

// File: rtl/i2c_bit_master.sv
module i2c_bit_master
  import i2c_bm_pkg::*;
#(
  parameter int UNIT_CLKS     = 4,
  parameter int CLK_MHZ       = 4,
  parameter int STRETCH_POLLS = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] dev_addr_i,
  input  logic [7:0] reg_addr_i,
  output logic       ready_o,
  output logic       done_o,
  output logic [1:0] status_o,
  output logic [7:0] rdata_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_drive_o,
  output logic       sda_drive_o
);
  localparam int STEP_CLKS = (CLK_MHZ > 0) ? CLK_MHZ : 1;
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [2:0] LAST_SEG = 3'd4;

  state_e     state_q;
  cmd_e       cmd_q;
  status_e    status_q;
  kind_e      cur_kind;
  logic [7:0] sh_q, dev_q, reg_q, dat_q, next_byte;
  logic [3:0] bit_q;
  logic [2:0] seg_q;
  logic       nak_q, rdn_q, done_q;
  logic       scl_s, sda_s, unit_done, poll_ok, poll_to, unit_go, poll_go;
  logic       accept, slot_last, seg_last, sda1, sda2;

  i2c_bm_sync u_sync_scl (.clk_i, .rst_ni, .d_i(scl_i), .q_o(scl_s));
  i2c_bm_sync u_sync_sda (.clk_i, .rst_ni, .d_i(sda_i), .q_o(sda_s));

  i2c_bm_delay #(.CYCLES(UNIT_CLKS)) u_unit (
    .clk_i, .rst_ni, .start_i(unit_go), .done_o(unit_done));

  i2c_bm_stretch #(.STEP_CLKS(STEP_CLKS), .POLLS(STRETCH_POLLS)) u_stretch (
    .clk_i, .rst_ni, .start_i(poll_go), .scl_i(scl_s), .ok_o(poll_ok), .timeout_o(poll_to));

  assign accept = (state_q == S_IDLE) && cmd_valid_i && (cmd_i <= 3'd5);

  always_comb begin
    unique case (cmd_q)
      CMD_START:               cur_kind = K_START;
      CMD_STOP:                cur_kind = K_STOP;
      CMD_WRITE:               cur_kind = K_WR;
      CMD_READ_ACK,
      CMD_READ_NACK:           cur_kind = K_RD;
      default:                 cur_kind = (seg_q == 3'd0) ? K_START :
                                          (seg_q == LAST_SEG) ? K_STOP : K_WR;
    endcase
  end

  assign seg_last  = (cmd_q == CMD_REG_WRITE) ? (seg_q == LAST_SEG) : 1'b1;
  assign slot_last = (cur_kind == K_START) || (cur_kind == K_STOP) || (bit_q == LAST_BIT);
  assign next_byte = (seg_q == 3'd0) ? dev_q : (seg_q == 3'd1) ? reg_q : dat_q;

  // sda1: level set one unit after SCL low; sda2: level once SCL high settled (1 = released)
  always_comb begin
    unique case (cur_kind)
      K_START: sda1 = 1'b1;
      K_STOP:  sda1 = 1'b0;
      K_WR:    sda1 = (bit_q == LAST_BIT) ? 1'b1 : sh_q[7];
      default: sda1 = (bit_q == LAST_BIT) ? (cmd_q != CMD_READ_ACK) : 1'b1;
    endcase
    sda2 = (cur_kind == K_START) ? 1'b0 : (cur_kind == K_STOP) ? 1'b1 : sda1;
  end

  assign unit_go = accept
                || ((state_q == S_LOW)   && unit_done)
                || ((state_q == S_REL)   && poll_ok)
                || ((state_q == S_HIGH1) && unit_done)
                || ((state_q == S_HIGH2) && unit_done && !(slot_last && seg_last));
  assign poll_go = (state_q == S_DATA) && unit_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cmd_q       <= CMD_START;
      status_q    <= ST_OK;
      sh_q        <= '0;
      dev_q       <= '0;
      reg_q       <= '0;
      dat_q       <= '0;
      bit_q       <= '0;
      seg_q       <= '0;
      nak_q       <= 1'b0;
      rdn_q       <= 1'b0;
      done_q      <= 1'b0;
      rdata_o     <= '0;
      scl_drive_o <= 1'b0;
      sda_drive_o <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          cmd_q       <= cmd_e'(cmd_i);
          dev_q       <= dev_addr_i;
          reg_q       <= reg_addr_i;
          dat_q       <= wdata_i;
          sh_q        <= wdata_i;
          bit_q       <= '0;
          seg_q       <= '0;
          nak_q       <= 1'b0;
          rdn_q       <= 1'b0;
          scl_drive_o <= 1'b1;
          state_q     <= S_LOW;
        end
        S_LOW: if (unit_done) begin
          sda_drive_o <= !sda1;
          state_q     <= S_DATA;
        end
        S_DATA: if (unit_done) begin
          scl_drive_o <= 1'b0;
          state_q     <= S_REL;
        end
        S_REL: if (poll_ok) begin
          state_q <= S_HIGH1;
        end else if (poll_to) begin
          scl_drive_o <= 1'b0;
          sda_drive_o <= 1'b0;
          status_q    <= ST_TIMEOUT;
          done_q      <= 1'b1;
          state_q     <= S_IDLE;
        end
        S_HIGH1: if (unit_done) begin
          if (cur_kind == K_RD && bit_q != LAST_BIT) sh_q <= {sh_q[6:0], sda_s};
          if (cur_kind == K_WR && bit_q == LAST_BIT && sda_s) nak_q <= 1'b1;
          if (cmd_q == CMD_READ_NACK && bit_q == LAST_BIT && !sda_s) rdn_q <= 1'b1;
          sda_drive_o <= !sda2;
          state_q     <= S_HIGH2;
        end
        S_HIGH2: if (unit_done) begin
          if (cur_kind == K_WR && bit_q != LAST_BIT) sh_q <= {sh_q[6:0], 1'b0};
          if (!slot_last) begin
            bit_q       <= bit_q + 1'b1;
            scl_drive_o <= 1'b1;
            state_q     <= S_LOW;
          end else if (!seg_last) begin
            seg_q       <= seg_q + 1'b1;
            bit_q       <= '0;
            sh_q        <= next_byte;
            scl_drive_o <= 1'b1;
            state_q     <= S_LOW;
          end else begin
            status_q <= rdn_q ? ST_RDNACK : (nak_q ? ST_NOACK : ST_OK);
            if (cur_kind == K_RD) rdata_o <= sh_q;
            done_q   <= 1'b1;
            state_q  <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o  = (state_q == S_IDLE);
  assign done_o   = done_q;
  assign status_o = status_q;

  assert_done_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_holds_cmd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(cmd_q));
  assert_timeout_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_TIMEOUT) |-> (!scl_drive_o && !sda_drive_o));
  assert_sda_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_drive_o && !$past(scl_drive_o) && (sda_drive_o != $past(sda_drive_o)))
    |-> ($past(cur_kind) == K_START || $past(cur_kind) == K_STOP || $past(state_q) == S_REL));
endmodule

// File: tb/tb_i2c_bit_master.sv
module tb_i2c_bit_master;
  import i2c_bm_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int UNIT  = 4;
  localparam int MHZ   = 4;
  localparam int POLLS = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd = '0;
  logic [7:0] wdata = '0, dev = '0, rega = '0;
  logic ready, done, scl_drv, sda_drv;
  logic [1:0] status;
  logic [7:0] rdata;
  logic scl_line, sda_line;
  logic slave_sda_low = 1'b0;
  int   hold = 0;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  longint cyc = 0;

  // slave configuration
  int         s_mode = 0;
  logic [7:0] s_rbyte = '0;
  logic [2:0] s_ack_low = '0;
  logic       s_nack_low = 1'b0;
  int         s_stretch_at = 0, s_stretch_len = 0;

  // monitor state
  int   starts = 0, stops = 0, nbits = 0, dones = 0;
  int   low_run = 0, low_min = 999, low_max = 0;
  logic cap [0:31];

  assign scl_line = !scl_drv && (hold == 0);
  assign sda_line = !sda_drv && !slave_sda_low;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_bit_master #(.UNIT_CLKS(UNIT), .CLK_MHZ(MHZ), .STRETCH_POLLS(POLLS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .wdata_i(wdata), .dev_addr_i(dev), .reg_addr_i(rega),
    .ready_o(ready), .done_o(done), .status_o(status), .rdata_o(rdata),
    .scl_i(scl_line), .sda_i(sda_line), .scl_drive_o(scl_drv), .sda_drive_o(sda_drv));

  function automatic logic slave_level(int b);
    case (s_mode)
      2:       return (b == 8) ? s_ack_low[0] : 1'b0;
      3, 4:    return (b < 8) ? !s_rbyte[7-b] : ((b == 8) && (s_mode == 4) && s_nack_low);
      5:       return (b == 9) ? s_ack_low[0] : (b == 18) ? s_ack_low[1] :
                      (b == 27) ? s_ack_low[2] : 1'b0;
      default: return 1'b0;
    endcase
  endfunction

  // slave model: updates on SCL falling edges
  logic s_prev_scl = 1'b1, s_prev_ready = 1'b1;
  int   fcnt = 0;
  always @(negedge clk) begin
    int f;
    logic fall, beg;
    fall = s_prev_scl && !scl_line;
    beg  = s_prev_ready && !ready;
    f    = beg ? 1 : (fall ? fcnt + 1 : fcnt);
    if (hold > 0) hold <= hold - 1;
    if (beg || fall) begin
      fcnt <= f;
      slave_sda_low <= slave_level(f - 1);
      if (f == s_stretch_at) hold <= s_stretch_len;
    end
    if (done) slave_sda_low <= 1'b0;
    s_prev_scl   <= scl_line;
    s_prev_ready <= ready;
  end

  // bus monitor
  logic m_prev_scl = 1'b1, m_prev_sda = 1'b0, m_prev_ready = 1'b1;
  always @(negedge clk) begin
    if (m_prev_ready && !ready) begin
      starts = 0; stops = 0; nbits = 0;
      low_run = 0; low_min = 999; low_max = 0;
    end
    if (scl_drv) low_run++;
    else if (low_run > 0) begin
      if (low_run < low_min) low_min = low_run;
      if (low_run > low_max) low_max = low_run;
      low_run = 0;
    end
    if (m_prev_scl && scl_line) begin
      if (!m_prev_sda && sda_drv) starts++;
      if (m_prev_sda && !sda_drv) stops++;
    end
    if (!m_prev_scl && scl_line && nbits < 32) begin
      cap[nbits] = sda_line;
      nbits++;
    end
    if (done) dones++;
    m_prev_scl   = scl_line;
    m_prev_sda   = sda_drv;
    m_prev_ready = ready;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] capbyte(int base);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7-i] = cap[base+i];
    return b;
  endfunction

  function automatic int exp_status(int c, logic [2:0] acks, logic nl);
    case (c)
      2:       return acks[0] ? 0 : 1;
      4:       return nl ? 2 : 0;
      5:       return (&acks) ? 0 : 1;
      default: return 0;
    endcase
  endfunction

  longint t_acc, t_done;
  int     d0;

  task automatic run(input int c, input logic [7:0] wd, input logic [7:0] da,
                     input logic [7:0] ra, input logic [7:0] rb, input logic [2:0] acks,
                     input logic nl, input int sat, input int slen);
    @(negedge clk);
    s_mode = c; s_rbyte = rb; s_ack_low = acks; s_nack_low = nl;
    s_stretch_at = sat; s_stretch_len = slen;
    d0 = dones;
    cmd = 3'(c); wdata = wd; dev = da; rega = ra; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    t_acc = cyc;
    while (!done) @(negedge clk);
    t_done = cyc;
    @(negedge clk);
    @(negedge clk);
    while (hold != 0 || !scl_line) @(negedge clk);
    s_stretch_at = 0;
  endtask

  task automatic verify(input int c, input logic [7:0] wd, input logic [7:0] da,
                        input logic [7:0] ra, input logic [7:0] rb, input logic [2:0] acks,
                        input logic nl);
    chk(dones == d0 + 1, "R11 one done per command", dones - d0, 1);
    chk(status == 2'(exp_status(c, acks, nl)), "R5/R7/R8 status", status, exp_status(c, acks, nl));
    chk(low_min == 2*UNIT && low_max == 2*UNIT, "R1 SCL low time", low_max, 2*UNIT);
    case (c)
      0: begin
        chk(starts == 1 && stops == 0, "R2 start edge", starts*10 + stops, 10);
        chk(!scl_drv && sda_drv, "R2 end state", {scl_drv, sda_drv}, 1);
      end
      1: begin
        chk(stops == 1 && starts == 0, "R3 stop edge", starts*10 + stops, 1);
        chk(!scl_drv && !sda_drv, "R3 released", {scl_drv, sda_drv}, 0);
      end
      2: begin
        chk(nbits == 9, "R4 nine clocks", nbits, 9);
        chk(capbyte(0) == wd, "R4 MSB-first byte", capbyte(0), wd);
        chk(starts == 0 && stops == 0, "R4 SDA steady while SCL high", starts + stops, 0);
      end
      3, 4: begin
        chk(nbits == 9, "R6 nine clocks", nbits, 9);
        chk(rdata == rb, "R6 read byte", rdata, rb);
        chk(cap[8] == ((c == 3) ? 1'b0 : !nl), "R6/R7 ninth-bit level", cap[8], (c == 3) ? 0 : !nl);
      end
      default: begin
        chk(nbits == 29, "R8 slot count", nbits, 29);
        chk(capbyte(1) == da, "R8 device byte", capbyte(1), da);
        chk(capbyte(10) == ra, "R8 register byte", capbyte(10), ra);
        chk(capbyte(19) == wd, "R8 data byte", capbyte(19), wd);
        chk(starts == 1 && stops == 1, "R8 start and stop", starts*10 + stops, 11);
      end
    endcase
  endtask

  task automatic do_cmd(input int c, input logic [7:0] wd, input logic [7:0] da,
                        input logic [7:0] ra, input logic [7:0] rb, input logic [2:0] acks,
                        input logic nl, input int sat, input int slen);
    run(c, wd, da, ra, rb, acks, nl, sat, slen);
    verify(c, wd, da, ra, rb, acks, nl);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd1234);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(ready && !done && !scl_drv && !sda_drv, "R11 reset state",
        {ready, done, scl_drv, sda_drv}, 8);

    // directed: start from released bus, start again with SDA low, stop, stop again
    do_cmd(0, 0, 0, 0, 0, 3'b111, 0, 0, 0);
    do_cmd(0, 0, 0, 0, 0, 3'b111, 0, 0, 0);  // R2 from SDA held low
    do_cmd(1, 0, 0, 0, 0, 3'b111, 0, 0, 0);
    do_cmd(1, 0, 0, 0, 0, 3'b111, 0, 0, 0);  // R3 from released bus
    do_cmd(2, 8'hA5, 0, 0, 0, 3'b001, 0, 0, 0);   // R4/R5 ack
    do_cmd(2, 8'h80, 0, 0, 0, 3'b000, 0, 0, 0);   // R5 no ack
    do_cmd(3, 0, 0, 0, 8'h3C, 3'b000, 0, 0, 0);   // R6
    do_cmd(4, 0, 0, 0, 8'hC1, 3'b000, 0, 0, 0);   // R7 floats high
    do_cmd(4, 0, 0, 0, 8'h7E, 3'b000, 1, 0, 0);   // R7 held low -> error
    do_cmd(5, 8'h5A, 8'hA0, 8'h13, 0, 3'b111, 0, 0, 0);  // R8 all acked
    do_cmd(5, 8'hFF, 8'h42, 8'h00, 0, 3'b010, 0, 0, 0);  // R8 continues past nacks

    // R9 stretch shorter than window
    do_cmd(2, 8'h96, 0, 0, 0, 3'b001, 0, 5, 150);
    chk(t_done - t_acc > 150, "R9 stretch delays completion", int'(t_done - t_acc), 151);

    // R10 stretch longer than window
    run(2, 8'h33, 0, 0, 0, 3'b001, 0, 3, POLLS*MHZ + 200);
    chk(status == 2'd3, "R10 timeout status", status, 3);
    chk(!scl_drv && !sda_drv, "R10 lines released", {scl_drv, sda_drv}, 0);
    chk(nbits == 2, "R10 aborted early", nbits, 2);
    chk(t_done - t_acc >= POLLS*MHZ, "R10 full window", int'(t_done - t_acc), POLLS*MHZ);
    do_cmd(2, 8'h0F, 0, 0, 0, 3'b001, 0, 0, 0);   // R10 recovery

    // R11 unknown codes ignored
    for (int k = 6; k < 8; k++) begin
      d0 = dones;
      @(negedge clk);
      cmd = 3'(k); cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (20) @(negedge clk);
      chk(ready && dones == d0 && !scl_drv, "R11 unknown code ignored", dones - d0, 0);
    end

    // random mix
    for (int it = 0; it < 30; it++) begin
      int c, nslots, sat;
      logic [2:0] acks;
      c = int'($urandom % 6);
      acks = 3'($urandom | ($urandom & 32'h7));
      nslots = (c <= 1) ? 1 : (c == 5) ? 29 : 9;
      sat = ($urandom % 3 == 0) ? 1 + int'($urandom % nslots) : 0;
      do_cmd(c, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), acks,
             1'($urandom), sat, 20 + int'($urandom % 130));
    end

    finish_run();
  end
endmodule